// File: doc/BRIEF.md
# Function Configuration Header Register File

This block holds the 64-byte type-0 configuration header of one bus function. A narrow access port presents a byte offset, an access width of one, two or four bytes, write data and separate read and write strobes; read data comes back on the clock after the read strobe and holds until the next read. Identification values, reset defaults and the decode window of each of the six base address registers are fixed by parameters. Writes are filtered per register: some fields take every write, some take none, and the base address registers follow the all-ones sizing handshake, so what reads back depends on the window size and on protected type bits rather than only on the data written.

Next to the access port the block presents, per base address register, the programmed base with its type bits cleared, whether it decodes IO or memory space, and a sticky flag that rises once a real (non-sizing) base with nonzero address bits has been written. A downstream decoder uses these to claim later cycles.

Top module: `cfg_header_regfile`

## Requirements
- R1: After reset every field reads its parameter default and all six enable flags are low.
- R2: A read of 1, 2 or 4 bytes returns the bytes from the offset upward in little-endian order, right-aligned with upper bits zero, on the clock after the read strobe; without a read strobe the read data holds.
- R3: An access whose width is not 1, 2 or 4, or whose last byte lies at or beyond offset 0x40, raises the error output on the next clock, changes no register, and a read returns zero.
- R4: A 4-byte write of 0xFFFFFFFF at a base register offset (0x10 + 4*n, n = 0..5) sets its address bits to the complement of (window size - 1) and keeps its type bits.
- R5: Bit 0 of a base register marks IO space; IO registers protect bits [1:0] and memory registers bits [3:0] against all writes; the per-register IO output equals bit 0.
- R6: Any other 4-byte write to a base register stores the written address bits.
- R7: A 4-byte write of 0xFFFFFFFE at offset 0x30 makes that register read 0xFFFFFFFF; any other value written there is stored as given.
- R8: One-byte writes update cache-line size (0x0C), latency timer (0x0D) and interrupt line (0x3C); a 2-byte write at 0x0C updates both 0x0C and 0x0D; one-byte writes anywhere else are ignored.
- R9: 2- and 4-byte writes at offset 0x04 store the low 16 bits into the command field; the status half is not written.
- R10: Vendor, device, class, revision, header type, subsystem, interrupt pin and grant/latency bytes are read-only at every width.
- R11: A base register's enable flag rises after a non-sizing write whose address bits are nonzero and stays high until reset.
- R12: With read and write strobes in the same cycle, the read returns the contents from before the write.
- R13: Each base output equals its base register with the protected type bits forced to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_off | input | 8 | Byte offset of the access |
| cfg_size | input | 3 | Access width in bytes |
| cfg_wr | input | 1 | Write strobe |
| cfg_rd | input | 1 | Read strobe |
| cfg_wdata | input | 32 | Write data, right-aligned |
| cfg_rdata | output | 32 | Read data of the last read |
| cfg_err | output | 1 | Rejected access flag, one cycle after the access |
| bar_base | output | 6x32 | Programmed base of each register, type bits zero |
| bar_io | output | 6 | IO space marker per register |
| bar_en | output | 6 | Sticky programmed flag per register |

## Verification
A read and a write can land in the same cycle; the bench drives both strobes together on the command word and on base registers, predicts the read from its model before applying the write, then reads again to see the new value. Sizing writes and ordinary base writes are also mixed on one register, so the enable flag and the protected type bits are judged after each access against a model that tracks both paths.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;
  localparam int HDR_BYTES = 64;
  localparam int NUM_BARS  = 6;
  localparam int OFF_W     = 6;

  localparam logic [7:0] OFF_CMD  = 8'h04;
  localparam logic [7:0] OFF_CLS  = 8'h0C;
  localparam logic [7:0] OFF_LAT  = 8'h0D;
  localparam logic [7:0] OFF_BAR0 = 8'h10;
  localparam logic [7:0] OFF_ROM  = 8'h30;
  localparam logic [7:0] OFF_INTL = 8'h3C;

  localparam logic [31:0] ALL_ONES  = 32'hFFFF_FFFF;
  localparam logic [31:0] ROM_PROBE = 32'hFFFF_FFFE;

  typedef logic [HDR_BYTES-1:0][7:0] hdr_img_t;

  function automatic logic [31:0] type_mask(input logic is_io);
    return is_io ? 32'h0000_0003 : 32'h0000_000F;
  endfunction
endpackage

// File: rtl/cfg_bar_slot.sv
module cfg_bar_slot
  import cfg_hdr_pkg::*;
#(
  parameter logic [31:0] RST_VAL = 32'h0,
  parameter int          LOG2    = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_hit,
  input  logic [31:0] wr_data,
  output logic [31:0] bar_q,
  output logic        en_q
);
  localparam logic [31:0] SIZE_ADDR = ~((32'h1 << LOG2) - 32'h1);

  logic [31:0] bar_d;
  logic        en_d;
  logic [31:0] tmask;
  logic        sizing;

  assign tmask  = type_mask(bar_q[0]);
  assign sizing = (wr_data == ALL_ONES);

  always_comb begin
    bar_d = bar_q;
    en_d  = en_q;
    if (wr_hit) begin
      bar_d = ((sizing ? SIZE_ADDR : wr_data) & ~tmask) | (bar_q & tmask);
      if (!sizing && ((wr_data & ~tmask) != 32'h0)) en_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bar_q <= RST_VAL;
      en_q  <= 1'b0;
    end else begin
      if (wr_hit) bar_q <= bar_d;
      en_q <= en_d;
    end
  end

  assert_type_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(bar_q & tmask));
  assert_sizing_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && sizing) |=> ((bar_q & ~tmask) == (SIZE_ADDR & ~tmask)));
  assert_plain_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !sizing) |=> ((bar_q & ~tmask) == ($past(wr_data) & ~tmask)));
  assert_enable_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> en_q);
endmodule

// File: rtl/cfg_rom_reg.sv
module cfg_rom_reg
  import cfg_hdr_pkg::*;
#(
  parameter logic [31:0] RST_VAL = 32'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_hit,
  input  logic [31:0] wr_data,
  output logic [31:0] rom_q
);
  logic [31:0] rom_d;

  always_comb begin
    rom_d = rom_q;
    if (wr_hit) rom_d = (wr_data == ROM_PROBE) ? ALL_ONES : wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rom_q <= RST_VAL;
    else if (wr_hit) rom_q <= rom_d;
  end

  assert_rom_probe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && wr_data == ROM_PROBE) |=> (rom_q == ALL_ONES));
  assert_rom_plain_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && wr_data != ROM_PROBE) |=> (rom_q == $past(wr_data)));
endmodule

// File: rtl/cfg_rd_mux.sv
module cfg_rd_mux
  import cfg_hdr_pkg::*;
(
  input  hdr_img_t          img,
  input  logic [OFF_W-1:0]  off,
  input  logic [2:0]        size,
  output logic [31:0]       data
);
  always_comb begin
    data = 32'h0;
    for (int k = 0; k < 4; k++) begin
      if (3'(k) < size) data[8*k +: 8] = img[OFF_W'(off + OFF_W'(k))];
    end
  end
endmodule

// File: rtl/cfg_header_regfile.sv
module cfg_header_regfile
  import cfg_hdr_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID  = 16'hA5C3,
  parameter logic [15:0] DEVICE_ID  = 16'h0172,
  parameter logic [15:0] CMD_RST    = 16'h0000,
  parameter logic [15:0] STATUS_VAL = 16'h0290,
  parameter logic [7:0]  REVISION   = 8'h03,
  parameter logic [23:0] CLASS_CODE = 24'h020000,
  parameter logic [7:0]  CLS_RST    = 8'h00,
  parameter logic [7:0]  LAT_RST    = 8'h00,
  parameter logic [7:0]  HDR_TYPE   = 8'h00,
  parameter logic [7:0]  BIST_VAL   = 8'h00,
  parameter logic [31:0] CIS_PTR    = 32'h0000_0000,
  parameter logic [15:0] SUB_VID    = 16'h1234,
  parameter logic [15:0] SUB_ID     = 16'h5678,
  parameter logic [31:0] ROM_RST    = 32'h0000_0000,
  parameter logic [7:0]  INTL_RST   = 8'hFF,
  parameter logic [7:0]  INT_PIN    = 8'h01,
  parameter logic [7:0]  MIN_GNT    = 8'h10,
  parameter logic [7:0]  MAX_LAT    = 8'h20,
  parameter logic [5:0][31:0] BAR_RST  = {32'h0, 32'h0, 32'h8, 32'h0, 32'h1, 32'h0},
  parameter logic [5:0][4:0]  BAR_LOG2 = {5'd5, 5'd20, 5'd4, 5'd16, 5'd8, 5'd12}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       cfg_off,
  input  logic [2:0]       cfg_size,
  input  logic             cfg_wr,
  input  logic             cfg_rd,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  output logic             cfg_err,
  output logic [5:0][31:0] bar_base,
  output logic [5:0]       bar_io,
  output logic [5:0]       bar_en
);
  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  // access qualification
  logic       size_ok, range_ok, bad, wr_ok;
  logic       wr_b, wr_h, wr_w;
  logic [8:0] end_off;

  assign size_ok  = (cfg_size == 3'd1) || (cfg_size == 3'd2) || (cfg_size == 3'd4);
  assign end_off  = {1'b0, cfg_off} + {6'b0, cfg_size};
  assign range_ok = (end_off <= 9'(HDR_BYTES));
  assign bad      = !(size_ok && range_ok);
  assign wr_ok    = cfg_wr && !bad;
  assign wr_b     = wr_ok && (cfg_size == 3'd1);
  assign wr_h     = wr_ok && (cfg_size == 3'd2);
  assign wr_w     = wr_ok && (cfg_size == 3'd4);

  // writable scalar fields
  logic [15:0] cmd_q, cmd_d;
  logic [7:0]  cls_q, cls_d, lat_q, lat_d, intl_q, intl_d;
  logic        cmd_we, cls_we, lat_we, intl_we;

  assign cmd_we  = (wr_h || wr_w) && (cfg_off == OFF_CMD);
  assign cls_we  = (wr_b || wr_h) && (cfg_off == OFF_CLS);
  assign lat_we  = (wr_b && (cfg_off == OFF_LAT)) || (wr_h && (cfg_off == OFF_CLS));
  assign intl_we = wr_b && (cfg_off == OFF_INTL);

  always_comb begin
    cmd_d  = cmd_q;
    cls_d  = cls_q;
    lat_d  = lat_q;
    intl_d = intl_q;
    if (cmd_we)  cmd_d  = cfg_wdata[15:0];
    if (cls_we)  cls_d  = cfg_wdata[7:0];
    if (lat_we)  lat_d  = wr_h ? cfg_wdata[15:8] : cfg_wdata[7:0];
    if (intl_we) intl_d = cfg_wdata[7:0];
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      cmd_q  <= CMD_RST;
      cls_q  <= CLS_RST;
      lat_q  <= LAT_RST;
      intl_q <= INTL_RST;
    end else begin
      if (cmd_we)  cmd_q  <= cmd_d;
      if (cls_we)  cls_q  <= cls_d;
      if (lat_we)  lat_q  <= lat_d;
      if (intl_we) intl_q <= intl_d;
    end
  end

  // base address registers
  logic [5:0][31:0] bar_q;

  for (genvar i = 0; i < NUM_BARS; i++) begin : g_bar
    logic hit;
    assign hit = wr_w && (cfg_off == OFF_BAR0 + 8'(4 * i));
    cfg_bar_slot #(.RST_VAL(BAR_RST[i]), .LOG2(int'(BAR_LOG2[i]))) u_slot (
      .clk     (clk),
      .rst_n   (rst_i_n),
      .wr_hit  (hit),
      .wr_data (cfg_wdata),
      .bar_q   (bar_q[i]),
      .en_q    (bar_en[i])
    );
    assign bar_io[i]   = bar_q[i][0];
    assign bar_base[i] = bar_q[i] & ~type_mask(bar_q[i][0]);
  end

  // expansion ROM register
  logic [31:0] rom_q;
  cfg_rom_reg #(.RST_VAL(ROM_RST)) u_rom (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .wr_hit  (wr_w && (cfg_off == OFF_ROM)),
    .wr_data (cfg_wdata),
    .rom_q   (rom_q)
  );

  // header image and read path
  hdr_img_t img;
  always_comb begin
    img = '0;
    {img[8'h01], img[8'h00]} = VENDOR_ID;
    {img[8'h03], img[8'h02]} = DEVICE_ID;
    {img[8'h05], img[8'h04]} = cmd_q;
    {img[8'h07], img[8'h06]} = STATUS_VAL;
    img[8'h08] = REVISION;
    {img[8'h0B], img[8'h0A], img[8'h09]} = CLASS_CODE;
    img[8'h0C] = cls_q;
    img[8'h0D] = lat_q;
    img[8'h0E] = HDR_TYPE;
    img[8'h0F] = BIST_VAL;
    for (int i = 0; i < NUM_BARS; i++) begin
      for (int k = 0; k < 4; k++) img[16 + 4*i + k] = bar_q[i][8*k +: 8];
    end
    {img[8'h2B], img[8'h2A], img[8'h29], img[8'h28]} = CIS_PTR;
    {img[8'h2D], img[8'h2C]} = SUB_VID;
    {img[8'h2F], img[8'h2E]} = SUB_ID;
    {img[8'h33], img[8'h32], img[8'h31], img[8'h30]} = rom_q;
    img[8'h3C] = intl_q;
    img[8'h3D] = INT_PIN;
    img[8'h3E] = MIN_GNT;
    img[8'h3F] = MAX_LAT;
  end

  logic [31:0] rd_word;
  cfg_rd_mux u_mux (
    .img  (img),
    .off  (cfg_off[OFF_W-1:0]),
    .size (cfg_size),
    .data (rd_word)
  );

  logic [31:0] rdata_d;
  logic        err_d;

  always_comb begin
    rdata_d = cfg_rdata;
    if (cfg_rd) rdata_d = bad ? 32'h0 : rd_word;
    err_d = (cfg_rd || cfg_wr) && bad;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      cfg_rdata <= 32'h0;
      cfg_err   <= 1'b0;
    end else begin
      if (cfg_rd) cfg_rdata <= rdata_d;
      cfg_err <= err_d;
    end
  end

  assert_err_read_zero_R3: assert property (@(posedge clk) disable iff (!rst_i_n)
    (cfg_rd && bad) |=> (cfg_err && cfg_rdata == 32'h0));
  assert_err_no_cmd_R3: assert property (@(posedge clk) disable iff (!rst_i_n)
    (cfg_wr && bad) |=> $stable(cmd_q));
  assert_rdata_hold_R2: assert property (@(posedge clk) disable iff (!rst_i_n)
    !cfg_rd |=> $stable(cfg_rdata));
  assert_base_clean_R13: assert property (@(posedge clk) disable iff (!rst_i_n)
    ((bar_base[0][1:0] == 2'b00) && (bar_base[1][1:0] == 2'b00) &&
     (bar_base[2][1:0] == 2'b00) && (bar_base[3][1:0] == 2'b00)));
endmodule

// File: tb/cfg_header_regfile_tb.sv
module cfg_header_regfile_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LOG2 [6] = '{12, 8, 16, 4, 20, 5};
  localparam logic [31:0] BAR_INIT [6] = '{32'h0, 32'h1, 32'h0, 32'h8, 32'h0, 32'h0};

  logic clk = 1'b0;
  logic rst_n;
  logic [7:0] cfg_off;
  logic [2:0] cfg_size;
  logic cfg_wr, cfg_rd;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic cfg_err;
  logic [5:0][31:0] bar_base;
  logic [5:0] bar_io, bar_en;

  int checks = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_header_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_off(cfg_off), .cfg_size(cfg_size),
    .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .cfg_err(cfg_err), .bar_base(bar_base),
    .bar_io(bar_io), .bar_en(bar_en)
  );

  // reference model
  logic [15:0] m_cmd;
  logic [7:0]  m_cls, m_lat, m_intl;
  logic [31:0] m_bar [6];
  logic        m_en [6];
  logic [31:0] m_rom;

  function automatic logic [31:0] tmask(input logic io);
    return io ? 32'h3 : 32'hF;
  endfunction

  function automatic logic acc_bad(input logic [7:0] off, input logic [2:0] sz);
    return !(sz == 3'd1 || sz == 3'd2 || sz == 3'd4) || (int'(off) + int'(sz) > 64);
  endfunction

  function automatic logic [7:0] m_byte(input int a);
    logic [7:0] b;
    b = 8'h0;
    case (a)
      0: b = 8'hC3;  1: b = 8'hA5;  2: b = 8'h72;  3: b = 8'h01;
      4: b = m_cmd[7:0];  5: b = m_cmd[15:8];
      6: b = 8'h90;  7: b = 8'h02;  8: b = 8'h03;
      9: b = 8'h00;  10: b = 8'h00;  11: b = 8'h02;
      12: b = m_cls; 13: b = m_lat;
      44: b = 8'h34; 45: b = 8'h12; 46: b = 8'h78; 47: b = 8'h56;
      48, 49, 50, 51: b = m_rom[8*(a-48) +: 8];
      60: b = m_intl; 61: b = 8'h01; 62: b = 8'h10; 63: b = 8'h20;
      default: if (a >= 16 && a < 40) b = m_bar[(a-16)/4][8*((a-16)%4) +: 8];
    endcase
    return b;
  endfunction

  function automatic logic [31:0] m_read(input logic [7:0] off, input logic [2:0] sz);
    logic [31:0] r;
    r = 32'h0;
    if (acc_bad(off, sz)) return r;
    for (int k = 0; k < int'(sz); k++) r[8*k +: 8] = m_byte(int'(off) + k);
    return r;
  endfunction

  task automatic m_write(input logic [7:0] off, input logic [2:0] sz, input logic [31:0] d);
    if (acc_bad(off, sz)) return;
    if (sz == 3'd1) begin
      if (off == 8'h0C) m_cls = d[7:0];
      if (off == 8'h0D) m_lat = d[7:0];
      if (off == 8'h3C) m_intl = d[7:0];
    end else if (sz == 3'd2) begin
      if (off == 8'h04) m_cmd = d[15:0];
      if (off == 8'h0C) begin m_cls = d[7:0]; m_lat = d[15:8]; end
    end else begin
      if (off == 8'h04) m_cmd = d[15:0];
      if (off == 8'h30) m_rom = (d == 32'hFFFF_FFFE) ? 32'hFFFF_FFFF : d;
      for (int i = 0; i < 6; i++) begin
        if (off == 8'(16 + 4*i)) begin
          logic [31:0] mk, a;
          mk = tmask(m_bar[i][0]);
          a  = (d == 32'hFFFF_FFFF) ? ~((32'h1 << LOG2[i]) - 32'h1) : d;
          m_bar[i] = (a & ~mk) | (m_bar[i] & mk);
          if (d != 32'hFFFF_FFFF && (d & ~mk) != 0) m_en[i] = 1'b1;
        end
      end
    end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one access, outputs sampled at the following falling edge
  task automatic access(input logic rd, input logic wr, input logic [7:0] off,
                        input logic [2:0] sz, input logic [31:0] d);
    logic [31:0] exp_rd;
    logic [31:0] prev_rd;
    prev_rd = cfg_rdata;
    exp_rd = rd ? m_read(off, sz) : prev_rd;
    @(negedge clk);
    cfg_rd = rd; cfg_wr = wr; cfg_off = off; cfg_size = sz; cfg_wdata = d;
    @(negedge clk);
    cfg_rd = 1'b0; cfg_wr = 1'b0;
    if (wr) m_write(off, sz, d);
    chk("R3 err flag", {31'b0, cfg_err}, {31'b0, (rd | wr) & acc_bad(off, sz)});
    if (rd) chk(acc_bad(off, sz) ? "R3 err read" : "R2/R12 read data", cfg_rdata, exp_rd);
    else    chk("R2 hold", cfg_rdata, prev_rd);
  endtask

  task automatic chk_outs();
    for (int i = 0; i < 6; i++) begin
      chk("R13 base", bar_base[i], m_bar[i] & ~tmask(m_bar[i][0]));
      chk("R5 io", {31'b0, bar_io[i]}, {31'b0, m_bar[i][0]});
      chk("R11 enable", {31'b0, bar_en[i]}, {31'b0, m_en[i]});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    process::self().srandom(32'd1729);
    rst_n = 1'b0; cfg_rd = 0; cfg_wr = 0; cfg_off = 0; cfg_size = 0; cfg_wdata = 0;
    m_cmd = 16'h0; m_cls = 8'h0; m_lat = 8'h0; m_intl = 8'hFF; m_rom = 32'h0;
    for (int i = 0; i < 6; i++) begin m_bar[i] = BAR_INIT[i]; m_en[i] = 1'b0; end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset image, read dword by dword
    for (int a = 0; a < 64; a += 4) access(1, 0, 8'(a), 3'd4, 32'h0);
    chk_outs();

    // R10: identity writes ignored at all widths
    access(0, 1, 8'h00, 3'd4, 32'hDEAD_BEEF);
    access(0, 1, 8'h08, 3'd1, 32'h55);
    access(0, 1, 8'h2C, 3'd2, 32'h9999);
    access(1, 0, 8'h00, 3'd4, 32'h0);   // R10 vendor/device
    access(1, 0, 8'h08, 3'd4, 32'h0);   // R10 class/rev
    access(1, 0, 8'h2C, 3'd4, 32'h0);   // R10 subsystem

    // R8: byte writes, writable and ignored
    access(0, 1, 8'h3C, 3'd1, 32'hA7);
    access(0, 1, 8'h3D, 3'd1, 32'hEE);
    access(0, 1, 8'h3E, 3'd1, 32'hEE);
    access(1, 0, 8'h3C, 3'd4, 32'h0);   // R8
    access(0, 1, 8'h0C, 3'd2, 32'h4020);
    access(1, 0, 8'h0C, 3'd2, 32'h0);   // R8 cls+lat

    // R9: command at 16 and 32 bits; status untouched
    access(0, 1, 8'h04, 3'd2, 32'h0146);
    access(1, 0, 8'h04, 3'd4, 32'h0);
    access(0, 1, 8'h04, 3'd4, 32'hFFFF_0007);
    access(1, 0, 8'h04, 3'd4, 32'h0);   // R9

    // R4/R5: sizing each BAR, then R6 plain write with low bits set
    for (int i = 0; i < 6; i++) begin
      access(0, 1, 8'(16 + 4*i), 3'd4, 32'hFFFF_FFFF);
      access(1, 0, 8'(16 + 4*i), 3'd4, 32'h0);   // R4
      access(0, 1, 8'(16 + 4*i), 3'd4, 32'hC012_345F);
      access(1, 0, 8'(16 + 4*i), 3'd4, 32'h0);   // R6
    end
    chk_outs();

    // R7: ROM probe and plain value
    access(0, 1, 8'h30, 3'd4, 32'hFFFF_FFFE);
    access(1, 0, 8'h30, 3'd4, 32'h0);
    access(0, 1, 8'h30, 3'd4, 32'h000C_0001);
    access(1, 0, 8'h30, 3'd4, 32'h0);   // R7

    // R3: rejected sizes and ranges leave state alone
    access(1, 1, 8'h04, 3'd3, 32'h1111);
    access(1, 0, 8'h3E, 3'd4, 32'h0);
    access(1, 1, 8'h40, 3'd1, 32'h0);
    access(0, 1, 8'h3C, 3'd0, 32'h0);
    access(1, 0, 8'h04, 3'd2, 32'h0);   // R3 cmd kept
    access(1, 0, 8'h3F, 3'd1, 32'h0);   // R2 last byte

    // R12: read and write in the same cycle
    access(1, 1, 8'h04, 3'd2, 32'h0333);
    access(1, 0, 8'h04, 3'd2, 32'h0);
    access(1, 1, 8'h14, 3'd4, 32'hFFFF_FFFF);
    access(1, 0, 8'h14, 3'd4, 32'h0);

    // random mix
    for (int n = 0; n < 600; n++) begin
      logic [7:0] off;
      logic [2:0] sz;
      logic [31:0] d;
      int pick;
      pick = $urandom_range(0, 9);
      off = (pick < 5) ? 8'(16 + 4*$urandom_range(0, 5)) : 8'($urandom_range(0, 70));
      sz = (pick < 5) ? 3'd4 : 3'($urandom_range(0, 5));
      case ($urandom_range(0, 3))
        0: d = 32'hFFFF_FFFF;
        1: d = 32'hFFFF_FFFE;
        2: d = 32'h0;
        default: d = $urandom;
      endcase
      access($urandom_range(0, 1) == 1, 1'b1, off, sz, d);
      access(1, 0, off, sz, 32'h0);
      if (n % 50 == 0) chk_outs();
    end
    chk_outs();

    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    m_cmd = 16'h0; m_cls = 8'h0; m_lat = 8'h0; m_intl = 8'hFF; m_rom = 32'h0;
    for (int i = 0; i < 6; i++) begin m_bar[i] = BAR_INIT[i]; m_en[i] = 1'b0; end
    chk_outs();                          // R1 after second reset
    access(1, 0, 8'h10, 3'd4, 32'h0);    // R1

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule